// File: doc/BRIEF.md
# Legacy Keyboard Port Trap Unit

This block lets system-management firmware stand in for a PS/2-style keyboard controller. It watches host I/O read and write strobes aimed at the keyboard data port (60h) and the keyboard command port (64h). Each matching access sets a sticky trap flag. Per-port, per-direction enable bits decide whether a set flag pulls the active-low system-management interrupt line. The same 16-bit control register steers the USB host interrupt onto either the system-management line or the normal interrupt line. It also follows the A20 gate passthrough sequence: a command-port write of D1h, then the next data-port write.

Software reads and writes the register through a simple configuration port: a one-cycle write strobe with 16 bits of data, and a read view that is always valid. Writing 2000h gives the operating system ownership: the interrupt goes to the normal line and no system-management interrupt is raised. Writing 2010h also sets the steering bit, which hands ownership to firmware.

Top module: `kbd_trap_unit`

## Requirements
- R1: After synchronous reset the register reads 2000h (with the USB interrupt input low), smi_n is 1 and irq_out is 0.
- R2: An I/O strobe sets one trap flag in the clock edge where it is seen, whatever the enable bits hold. The flags are: data-port read at bit 8, data-port write at bit 9, command-port read at bit 10, command-port write at bit 11.
- R3: A configuration write clears each of bits 8–11 and bit 15 where its data holds 1 and leaves the bit alone where the data holds 0. When a flag is set and cleared in the same edge, the set wins.
- R4: Accesses whose full address is neither 60h nor 64h set no flag. Cycles with no read or write strobe also set no flag.
- R5: Enable bits 0–3 pair with flags 8–11 in the same order. While an enabled flag is set, smi_n is 0 one cycle after the flag register changes. Once no condition for it remains, smi_n returns to 1.
- R6: Bit 12 reads the USB interrupt input, registered once. With bit 4 set, an active USB interrupt drives smi_n to 0.
- R7: With bit 13 set, irq_out follows the registered USB interrupt one cycle later. With bit 13 clear, irq_out stays 0.
- R8: With bit 5 set, a command-port write of data D1h sets bit 6 (in progress). The next data-port write clears bit 6 and sets bit 15 (ended). A command-port write with any other data does not start the sequence, and with bit 5 clear there is no sequence at all.
- R9: With bit 7 set, a set bit 15 drives smi_n to 0. Clearing bit 15 releases it.
- R10: Bits 6 and 12 are read-only and bit 14 always reads 0. Configuration writes to these bits have no effect.
- R11: Writing 2000h routes an active USB interrupt to irq_out with no system-management interrupt. Writing 2010h raises the system-management interrupt as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Host I/O cycle address |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_wdata | input | 8 | I/O write data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current register view |
| usb_irq_in | input | 1 | USB host interrupt request |
| smi_n | output | 1 | System-management interrupt, active low, registered |
| irq_out | output | 1 | Routed normal interrupt, registered |

## Verification
A trap hit and a software write-one-to-clear of the same flag can fall in one clock edge. The bench provokes this by raising a data-port read strobe and a configuration write with bit 8 set in the same cycle. It then expects bit 8 to read 1, because setting has priority. The bench also checks that a clear written while A20 is idle leaves the other sticky flags untouched.

// File: rtl/kbd_trap_pkg.sv
package kbd_trap_pkg;
  localparam int REG_W   = 16;
  localparam int NTRAP   = 4;
  // Register bit positions
  localparam int B_EN0   = 0;
  localparam int B_USMI  = 4;
  localparam int B_A20EN = 5;
  localparam int B_A20IP = 6;
  localparam int B_A20SE = 7;
  localparam int B_FLG0  = 8;
  localparam int B_IRQS  = 12;
  localparam int B_ROUTE = 13;
  localparam int B_A20DN = 15;
  localparam logic [REG_W-1:0] RESET_VAL = 16'h2000;

  typedef struct packed {
    logic [NTRAP-1:0] trap_en;
    logic             usb_smi_en;
    logic             a20_en;
    logic             a20_smi_en;
    logic             route_en;
  } ctrl_t;
endpackage

// File: rtl/kbd_trap_decode.sv
module kbd_trap_decode #(
  parameter int          IO_AW     = 16,
  parameter logic [15:0] DATA_PORT = 16'h0060,
  parameter logic [15:0] CMD_PORT  = 16'h0064
) (
  input  logic [IO_AW-1:0]             io_addr,
  input  logic                         io_rd,
  input  logic                         io_wr,
  output logic [kbd_trap_pkg::NTRAP-1:0] hit
);
  localparam logic [IO_AW-1:0] DP = IO_AW'(DATA_PORT);
  localparam logic [IO_AW-1:0] CP = IO_AW'(CMD_PORT);

  // index bit 1 selects port (0 data, 1 command), bit 0 selects direction (0 read, 1 write)
  for (genvar i = 0; i < kbd_trap_pkg::NTRAP; i++) begin : g_hit
    localparam logic [IO_AW-1:0] PORT = (i >= 2) ? CP : DP;
    localparam bit IS_WR = (i % 2) == 1;
    if (IS_WR) begin : g_wr
      assign hit[i] = io_wr && (io_addr == PORT);
    end else begin : g_rd
      assign hit[i] = io_rd && (io_addr == PORT);
    end
  end
endmodule

// File: rtl/kbd_a20_track.sv
module kbd_a20_track #(
  parameter int         IO_DW   = 8,
  parameter logic [7:0] GATE_CMD = 8'hD1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cmd_wr,
  input  logic             data_wr,
  input  logic [IO_DW-1:0] io_wdata,
  output logic             in_prog,
  output logic             done_pulse
);
  localparam logic [IO_DW-1:0] CMDV = IO_DW'(GATE_CMD);

  assign done_pulse = enable && in_prog && data_wr;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      in_prog <= 1'b0;
    end else if (done_pulse) begin
      in_prog <= 1'b0;
    end else if (cmd_wr && (io_wdata == CMDV)) begin
      in_prog <= 1'b1;
    end
  end
endmodule

// File: rtl/kbd_legsup_reg.sv
module kbd_legsup_reg
  import kbd_trap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [NTRAP-1:0] hit,
  input  logic             a20_done,
  input  logic             a20_busy,
  input  logic             usb_irq_in,
  output ctrl_t            ctrl,
  output logic [NTRAP-1:0] flags,
  output logic             a20_end,
  output logic             irq_q,
  output logic [REG_W-1:0] view
);
  logic [NTRAP-1:0] clr_flags;
  logic             clr_end;

  assign clr_flags = cfg_wr ? cfg_wdata[B_FLG0 +: NTRAP] : '0;
  assign clr_end   = cfg_wr && cfg_wdata[B_A20DN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl.trap_en    <= RESET_VAL[B_EN0 +: NTRAP];
      ctrl.usb_smi_en <= RESET_VAL[B_USMI];
      ctrl.a20_en     <= RESET_VAL[B_A20EN];
      ctrl.a20_smi_en <= RESET_VAL[B_A20SE];
      ctrl.route_en   <= RESET_VAL[B_ROUTE];
    end else if (cfg_wr) begin
      ctrl.trap_en    <= cfg_wdata[B_EN0 +: NTRAP];
      ctrl.usb_smi_en <= cfg_wdata[B_USMI];
      ctrl.a20_en     <= cfg_wdata[B_A20EN];
      ctrl.a20_smi_en <= cfg_wdata[B_A20SE];
      ctrl.route_en   <= cfg_wdata[B_ROUTE];
    end
  end

  // Sticky flags: hardware set has priority over software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      a20_end <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      flags   <= (flags & ~clr_flags) | hit;
      a20_end <= (a20_end & ~clr_end) | a20_done;
      irq_q   <= usb_irq_in;
    end
  end

  always_comb begin
    view                      = '0;
    view[B_EN0 +: NTRAP]      = ctrl.trap_en;
    view[B_USMI]              = ctrl.usb_smi_en;
    view[B_A20EN]             = ctrl.a20_en;
    view[B_A20IP]             = a20_busy;
    view[B_A20SE]             = ctrl.a20_smi_en;
    view[B_FLG0 +: NTRAP]     = flags;
    view[B_IRQS]              = irq_q;
    view[B_ROUTE]             = ctrl.route_en;
    view[B_A20DN]             = a20_end;
  end
endmodule

// File: rtl/kbd_smi_steer.sv
module kbd_smi_steer
  import kbd_trap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [NTRAP-1:0] flags,
  input  logic             a20_end,
  input  logic             irq_q,
  output logic             smi_n,
  output logic             irq_out
);
  logic smi_req;

  assign smi_req = (|(flags & ctrl.trap_en))
                 | (ctrl.usb_smi_en & irq_q)
                 | (ctrl.a20_smi_en & a20_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      smi_n   <= 1'b1;
      irq_out <= 1'b0;
    end else begin
      smi_n   <= ~smi_req;
      irq_out <= ctrl.route_en & irq_q;
    end
  end
endmodule

// File: rtl/kbd_trap_unit.sv
module kbd_trap_unit
  import kbd_trap_pkg::*;
#(
  parameter int          IO_AW     = 16,
  parameter int          IO_DW     = 8,
  parameter logic [15:0] DATA_PORT = 16'h0060,
  parameter logic [15:0] CMD_PORT  = 16'h0064,
  parameter logic [7:0]  GATE_CMD  = 8'hD1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [IO_DW-1:0] io_wdata,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             usb_irq_in,
  output logic             smi_n,
  output logic             irq_out
);
  logic [NTRAP-1:0] hit;
  logic [NTRAP-1:0] flags;
  ctrl_t            ctrl;
  logic             a20_busy, a20_done, a20_end, irq_q;

  kbd_trap_decode #(
    .IO_AW(IO_AW), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
  ) u_dec (
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .hit(hit)
  );

  kbd_a20_track #(.IO_DW(IO_DW), .GATE_CMD(GATE_CMD)) u_a20 (
    .clk(clk), .rst(rst), .enable(ctrl.a20_en),
    .cmd_wr(hit[3]), .data_wr(hit[1]), .io_wdata(io_wdata),
    .in_prog(a20_busy), .done_pulse(a20_done)
  );

  kbd_legsup_reg u_reg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .hit(hit), .a20_done(a20_done), .a20_busy(a20_busy),
    .usb_irq_in(usb_irq_in), .ctrl(ctrl), .flags(flags),
    .a20_end(a20_end), .irq_q(irq_q), .view(cfg_rdata)
  );

  kbd_smi_steer u_steer (
    .clk(clk), .rst(rst), .ctrl(ctrl), .flags(flags),
    .a20_end(a20_end), .irq_q(irq_q), .smi_n(smi_n), .irq_out(irq_out)
  );
endmodule

// File: rtl/kbd_trap_unit_chk.sv
module kbd_trap_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic [15:0] cfg_rdata,
  input logic        smi_n,
  input logic        irq_out
);
  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (smi_n && !irq_out));

  a_r2_data_read_flag: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == 16'h0060) |=> cfg_rdata[8]);

  a_r2_cmd_write_flag: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == 16'h0064) |=> cfg_rdata[11]);

  a_r5_trap_smi: assert property (@(posedge clk) disable iff (rst)
    (|(cfg_rdata[11:8] & cfg_rdata[3:0])) |=> !smi_n);

  a_r7_route_off: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[13] |=> !irq_out);

  a_r8_end_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_rdata[15]) |-> $past(cfg_rdata[6]));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[14] == 1'b0);
endmodule

bind kbd_trap_unit kbd_trap_unit_chk u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .cfg_rdata(cfg_rdata), .smi_n(smi_n), .irq_out(irq_out)
);

// File: tb/kbd_trap_unit_tb_top.sv
module kbd_trap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        usb_irq_in = 1'b0;
  logic        smi_n, irq_out;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  kbd_trap_unit dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .usb_irq_in(usb_irq_in), .smi_n(smi_n),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_cycle(input logic [15:0] a, input bit rd, input bit wr, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reg", cfg_rdata, 16'h2000);
    check("R1 smi_n", {15'd0, smi_n}, 16'd1);
    check("R1 irq_out", {15'd0, irq_out}, 16'd0);
  endtask

  task automatic t_trap_flags();
    for (int i = 0; i < 4; i++) begin
      io_cycle((i >= 2) ? 16'h0064 : 16'h0060, (i % 2) == 0, (i % 2) == 1, 8'h00);
      check("R2 flag", cfg_rdata, 16'h2000 | (16'h0100 << i));
      settle();
      check("R2 no smi when disabled", {15'd0, smi_n}, 16'd1);
      cfg_write(16'h2F00);
    end
    check("R3 cleared", cfg_rdata, 16'h2000);
  endtask

  task automatic t_ignored();
    io_cycle(16'h0061, 1'b1, 1'b0, 8'h00);
    io_cycle(16'h1060, 1'b0, 1'b1, 8'h00);
    io_cycle(16'h0064, 1'b0, 1'b0, 8'h00);
    check("R4 ignored", cfg_rdata, 16'h2000);
  endtask

  task automatic t_w1c();
    for (int i = 0; i < 4; i++)
      io_cycle((i >= 2) ? 16'h0064 : 16'h0060, (i % 2) == 0, (i % 2) == 1, 8'h00);
    cfg_write(16'h2000);
    check("R3 zero write keeps", cfg_rdata, 16'h2F00);
    cfg_write(16'h2500);
    check("R3 partial clear", cfg_rdata, 16'h2A00);
    // set and clear of bit 8 in one edge
    @(negedge clk);
    io_addr = 16'h0060; io_rd = 1'b1; cfg_wr = 1'b1; cfg_wdata = 16'h2100;
    @(negedge clk);
    io_rd = 1'b0; cfg_wr = 1'b0;
    check("R3 set wins", cfg_rdata, 16'h2B00);
    cfg_write(16'h2F00);
  endtask

  task automatic t_smi();
    cfg_write(16'h2002);
    io_cycle(16'h0060, 1'b0, 1'b1, 8'h55);
    settle();
    check("R5 smi asserted", {15'd0, smi_n}, 16'd0);
    cfg_write(16'h2202);
    settle();
    check("R5 smi released", {15'd0, smi_n}, 16'd1);
    cfg_write(16'h2000);
  endtask

  task automatic t_usb();
    usb_irq_in = 1'b1;
    settle(); settle();
    check("R6 irq status", cfg_rdata, 16'h3000);
    check("R11 os owns irq_out", {15'd0, irq_out}, 16'd1);
    check("R11 os owns no smi", {15'd0, smi_n}, 16'd1);
    cfg_write(16'h2010);
    settle();
    check("R6 R11 firmware smi", {15'd0, smi_n}, 16'd0);
    cfg_write(16'h0010);
    settle();
    check("R7 route off", {15'd0, irq_out}, 16'd0);
    usb_irq_in = 1'b0;
    settle(); settle();
    check("R6 smi released", {15'd0, smi_n}, 16'd1);
    cfg_write(16'h2000);
  endtask

  task automatic t_a20();
    io_cycle(16'h0064, 1'b0, 1'b1, 8'hD1);
    check("R8 disabled no seq", cfg_rdata, 16'h2800);
    cfg_write(16'h2820);
    io_cycle(16'h0064, 1'b0, 1'b1, 8'hAB);
    check("R8 other cmd", cfg_rdata, 16'h2820);
    io_cycle(16'h0064, 1'b0, 1'b1, 8'hD1);
    check("R8 in progress", cfg_rdata, 16'h2860);
    io_cycle(16'h0060, 1'b0, 1'b1, 8'hDF);
    check("R8 ended", cfg_rdata, 16'hAA20);
    cfg_write(16'h20A0);
    settle();
    check("R9 end smi", {15'd0, smi_n}, 16'd0);
    cfg_write(16'hAFA0);
    check("R9 end cleared", cfg_rdata, 16'h20A0);
    settle();
    check("R9 smi released", {15'd0, smi_n}, 16'd1);
    cfg_write(16'h2000);
  endtask

  task automatic t_readonly();
    cfg_write(16'h5040);
    check("R10 ro bits", cfg_rdata, 16'h0000);
    cfg_write(16'h2000);
    check("R10 restore", cfg_rdata, 16'h2000);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_trap_flags();
    t_ignored();
    t_w1c();
    t_smi();
    t_usb();
    t_a20();
    t_readonly();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule